// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Address Generator

This block turns one transfer descriptor into a stream of memory requests. A transfer is a rectangle: a number of rows, each holding the same number of bytes. The source and the destination each start at their own base address and move to their next row by their own stride, so one descriptor can gather from one layout and scatter into another. Each request carries a source address, a destination address and a byte count, and is held until the memory side accepts it.

Lengths use a minus-one encoding, so a field value of zero means one unit. A plain linear copy is a single row. All addresses, strides and row lengths are aligned to a beat of `BEAT_BYTES`, and the bits below that alignment are ignored. Each row is cut into bursts of at most `MAX_BURST` bytes, and no burst crosses the end of a row. If the repeat flag is set, the descriptor runs again from its first row with no new start. The abort input stops the generator at once. A side wired to a peripheral stream, rather than to memory, is chosen by parameter and reports no address.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While reset is high and in the cycle after it, `req_valid_o` and `done_o` are 0, and all address outputs and `req_bytes_o` are 0.
- R2: When `start_i` is high at a clock edge with no transfer running and `abort_i` low, `req_valid_o` is 1 from the next cycle on, and the first request carries the aligned start addresses.
- R3: A row holds `xlen_m1_i + 1` bytes, with the low log2(`BEAT_BYTES`) bits of `xlen_m1_i` taken as ones. There are `ylen_m1_i + 1` rows, so a value of 0 gives one linear row.
- R4: Each request carries between 1 and `MAX_BURST` bytes and a multiple of `BEAT_BYTES`. Bursts inside a row follow one another, each address being the previous one plus the previous byte count. The last burst of a row ends exactly at the row end.
- R5: Each row starts at the previous row start plus that side's stride. The two strides are independent. The low log2(`BEAT_BYTES`) bits of start addresses and strides are treated as zero, so every address is beat-aligned.
- R6: While `req_valid_o` is 1 and `req_ready_i` is 0 with no abort, the request stays on the outputs unchanged.
- R7: `done_o` pulses for one cycle in the cycle after the last burst of the last row is accepted. Without repeat, `req_valid_o` is 0 in that same cycle.
- R8: With `cyclic_i` set at start, accepting the last burst of the last row brings back the first burst of the first row in the next cycle, and `done_o` pulses once per pass.
- R9: When `abort_i` is high at a clock edge, `req_valid_o` is 0 from the next cycle on until a later start. Abort takes priority over start and over acceptance.
- R10: A start seen while a transfer is running is ignored: the running transfer goes on unchanged.
- R11: A side built as a stream (`SRC_MEM` or `DST_MEM` set to 0) drives its request address and status address as constant 0.
- R12: `cur_src_o` and `cur_dst_o` show the addresses of the request being presented or, when idle, of the last one presented.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Loads the descriptor inputs and begins a transfer |
| abort_i | input | 1 | Stops the transfer and returns to idle |
| src_addr_i | input | ADDR_W | Source start address |
| dst_addr_i | input | ADDR_W | Destination start address |
| src_stride_i | input | ADDR_W | Source row-to-row step in bytes |
| dst_stride_i | input | ADDR_W | Destination row-to-row step in bytes |
| xlen_m1_i | input | LEN_W | Bytes per row minus one |
| ylen_m1_i | input | YLEN_W | Rows minus one |
| cyclic_i | input | 1 | Repeat the descriptor without a new start |
| req_valid_o | output | 1 | A request is presented |
| req_ready_i | input | 1 | Memory side accepts the presented request |
| req_src_o | output | ADDR_W | Source address of the request |
| req_dst_o | output | ADDR_W | Destination address of the request |
| req_bytes_o | output | LEN_W+1 | Byte count of the request |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| cur_src_o | output | ADDR_W | Current source address for status |
| cur_dst_o | output | ADDR_W | Current destination address for status |

## Verification
A wrong row counter or burst offset shows up on the request ports in the first cycle after the faulty acceptance. It appears as a byte count that runs past the row end, a missing or extra row step in the addresses, or a `done_o` pulse in the wrong cycle. A wrong row-start register is first seen at the next row boundary, as an address that is off by a stride or by part of one. For this reason the reference model is compared against every output on every clock, across several ready patterns, row shapes, misaligned inputs, repeat passes and aborts.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } gen_state_e;
endpackage

// File: rtl/dma2d_desc_reg.sv
module dma2d_desc_reg #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int YLEN_W = 8,
  parameter int AL     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [ADDR_W-1:0] sstr_in,
  input  logic [ADDR_W-1:0] dstr_in,
  input  logic [LEN_W-1:0]  xlen_in,
  input  logic [YLEN_W-1:0] ylen_in,
  input  logic              cyc_in,
  output logic [ADDR_W-1:0] al_src,
  output logic [ADDR_W-1:0] al_dst,
  output logic [LEN_W:0]    al_rb,
  output logic [ADDR_W-1:0] q_src,
  output logic [ADDR_W-1:0] q_dst,
  output logic [ADDR_W-1:0] q_sstr,
  output logic [ADDR_W-1:0] q_dstr,
  output logic [LEN_W:0]    q_rb,
  output logic [YLEN_W-1:0] q_ylast,
  output logic              q_cyc
);
  localparam logic [ADDR_W-1:0] AMASK = ~((ADDR_W'(1) << AL) - ADDR_W'(1));
  localparam logic [LEN_W-1:0]  LONES = (LEN_W'(1) << AL) - LEN_W'(1);

  logic [ADDR_W-1:0] al_sstr, al_dstr;

  always_comb begin
    al_src  = src_in & AMASK;
    al_dst  = dst_in & AMASK;
    al_sstr = sstr_in & AMASK;
    al_dstr = dstr_in & AMASK;
    al_rb   = {1'b0, xlen_in | LONES} + (LEN_W+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_src <= '0; q_dst <= '0; q_sstr <= '0; q_dstr <= '0;
      q_rb <= '0; q_ylast <= '0; q_cyc <= 1'b0;
    end else if (load) begin
      q_src   <= al_src;
      q_dst   <= al_dst;
      q_sstr  <= al_sstr;
      q_dstr  <= al_dstr;
      q_rb    <= al_rb;
      q_ylast <= ylen_in;
      q_cyc   <= cyc_in;
    end
  end
endmodule

// File: rtl/dma2d_side.sv
module dma2d_side #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int AL     = 2,
  parameter bit IS_MEM = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              restart,
  input  logic [ADDR_W-1:0] base,
  input  logic              step_row,
  input  logic [ADDR_W-1:0] stride,
  input  logic              step_burst,
  input  logic [LEN_W:0]    burst_bytes,
  output logic [ADDR_W-1:0] addr
);
  generate
    if (IS_MEM) begin : g_mem
      logic [ADDR_W-1:0] row_q, addr_q;
      logic [ADDR_W-1:0] next_row;
      assign next_row = row_q + stride;

      always_ff @(posedge clk) begin
        if (rst) begin
          row_q  <= '0;
          addr_q <= '0;
        end else if (load) begin
          row_q  <= load_addr;
          addr_q <= load_addr;
        end else if (restart) begin
          row_q  <= base;
          addr_q <= base;
        end else if (step_row) begin
          row_q  <= next_row;
          addr_q <= next_row;
        end else if (step_burst) begin
          addr_q <= addr_q + ADDR_W'(burst_bytes);
        end
      end
      assign addr = addr_q;

      // R5
      addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        addr_q[AL-1:0] == '0);
    end else begin : g_stream
      logic side_unused;
      assign side_unused = ^{clk, rst, load, load_addr, restart, base,
                             step_row, stride, step_burst, burst_bytes};
      assign addr = '0;
    end
  endgenerate
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int YLEN_W     = 8,
  parameter int BEAT_BYTES = 4,
  parameter int MAX_BURST  = 16,
  parameter bit SRC_MEM    = 1'b1,
  parameter bit DST_MEM    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [ADDR_W-1:0] src_stride_i,
  input  logic [ADDR_W-1:0] dst_stride_i,
  input  logic [LEN_W-1:0]  xlen_m1_i,
  input  logic [YLEN_W-1:0] ylen_m1_i,
  input  logic              cyclic_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_src_o,
  output logic [ADDR_W-1:0] req_dst_o,
  output logic [LEN_W:0]    req_bytes_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] cur_src_o,
  output logic [ADDR_W-1:0] cur_dst_o
);
  import dma2d_pkg::*;

  localparam int AL = $clog2(BEAT_BYTES);
  localparam int CW = LEN_W + 1;
  localparam logic [CW-1:0] MAXB = CW'(MAX_BURST);

  function automatic logic [CW-1:0] burst_of(input logic [CW-1:0] rb,
                                             input logic [CW-1:0] off);
    logic [CW-1:0] rem;
    rem = rb - off;
    return (rem > MAXB) ? MAXB : rem;
  endfunction

  gen_state_e        state_q;
  logic [CW-1:0]     off_q, bytes_q, nxt_off;
  logic [YLEN_W-1:0] row_q;
  logic              done_q;

  logic [ADDR_W-1:0] al_src, al_dst, q_src, q_dst, q_sstr, q_dstr;
  logic [CW-1:0]     al_rb, q_rb;
  logic [YLEN_W-1:0] q_ylast;
  logic              q_cyc;
  logic              running, accept, in_row, last_row;
  logic              do_load, do_burst, do_row, do_restart;

  assign running    = (state_q == GEN_RUN);
  assign accept     = running && req_ready_i && !abort_i;
  assign nxt_off    = off_q + bytes_q;
  assign in_row     = nxt_off < q_rb;
  assign last_row   = (row_q == q_ylast);
  assign do_load    = !running && start_i && !abort_i;
  assign do_burst   = accept && in_row;
  assign do_row     = accept && !in_row && !last_row;
  assign do_restart = accept && !in_row && last_row && q_cyc;

  dma2d_desc_reg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .YLEN_W(YLEN_W), .AL(AL)) u_desc (
    .clk(clk), .rst(rst), .load(do_load),
    .src_in(src_addr_i), .dst_in(dst_addr_i),
    .sstr_in(src_stride_i), .dstr_in(dst_stride_i),
    .xlen_in(xlen_m1_i), .ylen_in(ylen_m1_i), .cyc_in(cyclic_i),
    .al_src(al_src), .al_dst(al_dst), .al_rb(al_rb),
    .q_src(q_src), .q_dst(q_dst), .q_sstr(q_sstr), .q_dstr(q_dstr),
    .q_rb(q_rb), .q_ylast(q_ylast), .q_cyc(q_cyc)
  );

  dma2d_side #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .AL(AL), .IS_MEM(SRC_MEM)) u_src (
    .clk(clk), .rst(rst), .load(do_load), .load_addr(al_src),
    .restart(do_restart), .base(q_src), .step_row(do_row), .stride(q_sstr),
    .step_burst(do_burst), .burst_bytes(bytes_q), .addr(req_src_o)
  );

  dma2d_side #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .AL(AL), .IS_MEM(DST_MEM)) u_dst (
    .clk(clk), .rst(rst), .load(do_load), .load_addr(al_dst),
    .restart(do_restart), .base(q_dst), .step_row(do_row), .stride(q_dstr),
    .step_burst(do_burst), .burst_bytes(bytes_q), .addr(req_dst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GEN_IDLE;
      off_q   <= '0;
      row_q   <= '0;
      bytes_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        state_q <= GEN_IDLE;
      end else if (do_load) begin
        state_q <= GEN_RUN;
        off_q   <= '0;
        row_q   <= '0;
        bytes_q <= burst_of(al_rb, '0);
      end else if (accept) begin
        if (in_row) begin
          off_q   <= nxt_off;
          bytes_q <= burst_of(q_rb, nxt_off);
        end else begin
          off_q   <= '0;
          bytes_q <= burst_of(q_rb, '0);
          if (!last_row) begin
            row_q <= row_q + YLEN_W'(1);
          end else begin
            row_q  <= '0;
            done_q <= 1'b1;
            if (!q_cyc) state_q <= GEN_IDLE;
          end
        end
      end
    end
  end

  assign req_valid_o = running;
  assign req_bytes_o = bytes_q;
  assign done_o      = done_q;
  assign cur_src_o   = req_src_o;
  assign cur_dst_o   = req_dst_o;

  // R4
  burst_size_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> (req_bytes_o != '0 && req_bytes_o <= MAXB && req_bytes_o[AL-1:0] == '0));
  // R4
  row_end_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> (off_q + req_bytes_o <= q_rb));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !req_ready_i && !abort_i) |=>
      (req_valid_o && $stable(req_src_o) && $stable(req_dst_o) && $stable(req_bytes_o)));
  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> !req_valid_o);
  // R7
  done_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(req_valid_o && req_ready_i && !abort_i));
endmodule

// File: tb/sim_dma2d_addr_gen.sv
module sim_dma2d_addr_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, abort = 1'b0, ready = 1'b1, cyc = 1'b0;
  logic [31:0] src = '0, dst = '0, sstr = '0, dstr = '0;
  logic [15:0] xl = '0;
  logic [7:0]  yl = '0;
  logic        v0, d0, v1, d1;
  logic [31:0] s0, t0, cs0, ct0, s1, t1, cs1, ct1;
  logic [16:0] b0, b1;

  int checks = 0, errors = 0, rmode = 0, cnt = 0;
  int dut_done = 0, mdl_done = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma2d_addr_gen u0 (
    .clk(clk), .rst(rst), .start_i(start), .abort_i(abort),
    .src_addr_i(src), .dst_addr_i(dst), .src_stride_i(sstr), .dst_stride_i(dstr),
    .xlen_m1_i(xl), .ylen_m1_i(yl), .cyclic_i(cyc),
    .req_valid_o(v0), .req_ready_i(ready), .req_src_o(s0), .req_dst_o(t0),
    .req_bytes_o(b0), .done_o(d0), .cur_src_o(cs0), .cur_dst_o(ct0)
  );

  dma2d_addr_gen #(.DST_MEM(1'b0)) u1 (
    .clk(clk), .rst(rst), .start_i(start), .abort_i(abort),
    .src_addr_i(src), .dst_addr_i(dst), .src_stride_i(sstr), .dst_stride_i(dstr),
    .xlen_m1_i(xl), .ylen_m1_i(yl), .cyclic_i(cyc),
    .req_valid_o(v1), .req_ready_i(ready), .req_src_o(s1), .req_dst_o(t1),
    .req_bytes_o(b1), .done_o(d1), .cur_src_o(cs1), .cur_dst_o(ct1)
  );

  // behavioural reference model
  bit m_busy = 0, m_done = 0, m_cyc = 0;
  logic [31:0] m_ds, m_dd, m_ss, m_sd, m_rs, m_rd, m_cs, m_cd;
  int m_rb, m_yl, m_off, m_row, m_by;

  function automatic int mn(int a, int b);
    return (a < b) ? a : b;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_cs = 0; m_cd = 0; m_by = 0;
    end else begin
      m_done = 0;
      if (abort) m_busy = 0;
      else if (!m_busy) begin
        if (start) begin
          m_ds = src & ~32'd3; m_dd = dst & ~32'd3;
          m_ss = sstr & ~32'd3; m_sd = dstr & ~32'd3;
          m_rb = int'(xl | 16'd3) + 1; m_yl = int'(yl); m_cyc = cyc;
          m_rs = m_ds; m_rd = m_dd; m_cs = m_ds; m_cd = m_dd;
          m_off = 0; m_row = 0; m_by = mn(m_rb, 16); m_busy = 1;
        end
      end else if (ready) begin
        if (m_off + m_by < m_rb) begin
          m_cs += m_by; m_cd += m_by; m_off += m_by; m_by = mn(m_rb - m_off, 16);
        end else if (m_row != m_yl) begin
          m_row++; m_rs += m_ss; m_rd += m_sd; m_cs = m_rs; m_cd = m_rd;
          m_off = 0; m_by = mn(m_rb, 16);
        end else begin
          m_done = 1; mdl_done++; m_off = 0; m_row = 0; m_by = mn(m_rb, 16);
          if (m_cyc) begin
            m_rs = m_ds; m_rd = m_dd; m_cs = m_ds; m_cd = m_dd;
          end else m_busy = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare all outputs every clock, shortly after the edge
  always @(posedge clk) begin
    #2;
    if (!rst && !finished) begin
      if (d0) dut_done++;
      chk(v0 == m_busy, "R2 R7 R9 R10 req_valid", v0, m_busy);
      chk(d0 == m_done, "R7 R8 done", d0, m_done);
      chk(s0 == m_cs, "R4 R5 R6 req_src", s0, m_cs);
      chk(t0 == m_cd, "R4 R5 R6 req_dst", t0, m_cd);
      chk(int'(b0) == m_by, "R3 R4 req_bytes", b0, m_by);
      chk(cs0 == m_cs && ct0 == m_cd, "R12 cur_src cur_dst", cs0, m_cs);
      chk(t1 == 32'd0 && ct1 == 32'd0, "R11 stream dst address", t1, 0);
      chk(s1 == m_cs && v1 == m_busy, "R11 memory src beside stream dst", s1, m_cs);
    end
  end

  always @(negedge clk) begin
    cnt++;
    case (rmode)
      0: ready <= 1'b1;
      1: ready <= (cnt % 3) != 0;
      default: ready <= (cnt % 4) == 1;
    endcase
  end

  task automatic go(input logic [31:0] a, input logic [31:0] b, input logic [31:0] sa,
                    input logic [31:0] sb, input logic [15:0] x, input logic [7:0] y,
                    input logic c);
    @(negedge clk);
    src = a; dst = b; sstr = sa; dstr = sb; xl = x; yl = y; cyc = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 600 && v0; i++) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!v0 && !d0, "R1 valid/done in reset", v0, 0);
    chk(s0 == 0 && t0 == 0 && b0 == 0, "R1 outputs in reset", s0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!v0 && !d0 && cs0 == 0 && ct0 == 0, "R1 after reset", v0, 0);

    // R3 R4 linear row: 40 bytes -> 16,16,8
    rmode = 0;
    go(32'h1000, 32'h8000, 0, 0, 16'd39, 8'd0, 1'b0);
    chk(v0 && s0 == 32'h1000 && b0 == 17'd16, "R2 first request", b0, 16);
    drain();

    // R5 misaligned bases and strides, 3 rows of 24 bytes, stalls, R10 restart attempt
    rmode = 1;
    go(32'h2003, 32'h9002, 32'd101, 32'h43, 16'd22, 8'd2, 1'b0);
    repeat (3) @(negedge clk);
    go(32'h5550, 32'h6660, 32'd8, 32'd8, 16'd3, 8'd0, 1'b0);
    drain();

    // R3 length low bits as ones: x=5 -> 8 bytes, slow ready
    rmode = 2;
    go(32'h300, 32'h400, 32'd64, 32'd32, 16'd5, 8'd3, 1'b0);
    drain();

    // R8 cyclic: two rows of 16 bytes, repeats until abort
    rmode = 0;
    dut_done = 0; mdl_done = 0;
    go(32'h7000, 32'hA000, 32'h100, 32'h200, 16'd15, 8'd1, 1'b1);
    repeat (12) @(negedge clk);
    chk(dut_done == mdl_done && dut_done >= 4, "R8 done per pass", dut_done, mdl_done);
    chk(v0, "R8 still running", v0, 1);
    // R9 abort
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(!v0, "R9 idle after abort", v0, 0);
    repeat (5) @(negedge clk);
    chk(!v0 && !d0, "R9 no requests after abort", v0, 0);

    // R9 abort mid-row in a non-cyclic run, then a fresh start
    rmode = 1;
    go(32'hC000, 32'hD000, 32'd64, 32'd64, 16'd63, 8'd2, 1'b0);
    repeat (4) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(!v0, "R9 abort mid-row", v0, 0);
    go(32'hE000, 32'hF000, 32'd48, 32'd80, 16'd31, 8'd1, 1'b0);
    drain();
    repeat (3) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule